// File: doc/BRIEF.md
# Decimating FIR Tap Cell

One multiply-accumulate tap for a cascadable, systolic FIR array. Every cell in the array receives the same 8-bit input sample on its X register. Coefficients enter each cell from the previous one, are held in a C register, and are forwarded to the next cell. The forwarding path has a selectable delay of zero to three extra registers. The delay slows the coefficient's progress through the array relative to the data, so the array produces an output every 1, 2, 3 or 4 input samples.

On each clock the cell multiplies the held sample by the held coefficient. Each operand is read as unsigned or as two's complement according to a flag that travels with it. The product is extended to 26 bits and added into a 26-bit accumulator. A clear input starts a new sum by loading the product instead of adding it. The data enable and the coefficient enable are both active low, and each takes effect one clock after it is sampled.

Top module: `fir_tap_cell`

## Requirements
- R1: While `rst` is high at a rising edge, every register clears. After reset, `acc_out`, `cout` and `cout_signed` read zero, and both enables behave as deasserted.
- R2: Every clock, `acc_out` becomes its previous value plus the product of the X and C registers, with both operands taken as 8-bit unsigned when their flags are 0.
- R3: A flag value of 1 makes its operand two's complement. The data flag is `din_signed` and the coefficient flag is `cin_signed`. The signed product is sign-extended to 26 bits before it is accumulated.
- R4: `din_en_n` is registered before use. When it was low at edge k, the edge k+1 loads `din` and `din_signed` into the X register. That product reaches `acc_out` at edge k+2.
- R5: When `din_en_n` was high at edge k, the edge k+1 loads zero (unsigned) into the X register. From then on the accumulator does not change, except that a clear zeroes it.
- R6: `cin_en_n` is registered before use. When it was low at edge k, the edge k+1 loads `cin`/`cin_signed` into the C register and shifts the active decimation stages.
- R7: When `cin_en_n` was high at edge k, the edge k+1 leaves the C register and all decimation stages unchanged. With `decim_mode` unchanged, `cout` and `cout_signed` therefore hold.
- R8: `decim_mode` encodes the number of decimation stages between the C register and `cout`. With 00, `cout` shows the C register. With 01, 10 and 11, one, two or three stages are inserted. Only stages in use are loaded.
- R9: With `acc_clear` high at an edge, the accumulator loads the current product instead of adding it.
- R10: Accumulation wraps modulo 2^26.
- R11: `cout_signed` is the coefficient flag that was captured together with the value on `cout`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 8 | Broadcast data sample |
| din_signed | input | 1 | 1 = data is two's complement |
| din_en_n | input | 1 | Data load enable, active low, one clock latency |
| cin | input | 8 | Coefficient from previous cell |
| cin_signed | input | 1 | 1 = coefficient is two's complement |
| cin_en_n | input | 1 | Coefficient load enable, active low, one clock latency |
| decim_mode | input | 2 | Number of decimation stages (0 to 3) |
| acc_clear | input | 1 | Load product into accumulator instead of adding |
| acc_out | output | 26 | Accumulator value |
| cout | output | 8 | Forwarded coefficient |
| cout_signed | output | 1 | Signedness flag of forwarded coefficient |

## Verification
The hardest state to reach from the ports is the accumulator crossing 2^26. The largest unsigned product is 65025, so an unsigned crossing needs more than a thousand clocks of maximum operands with no clear. The stimulus holds both operands at 255 for 1100 clocks to force that crossing. It also clears the accumulator onto a negative signed product, which reaches the wrapped value at once. A reference model tracks the decimation chain while the mode changes mid-stream with the coefficient enable toggling. This shows that the unused stages stay frozen and that their old contents reappear once the mode selects them again.

// File: rtl/fir_tap_cell.sv
module fir_tap_cell #(
  parameter int DW = 8,
  parameter int AW = 26
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] din,
  input  logic          din_signed,
  input  logic          din_en_n,
  input  logic [DW-1:0] cin,
  input  logic          cin_signed,
  input  logic          cin_en_n,
  input  logic [1:0]    decim_mode,
  input  logic          acc_clear,
  output logic [AW-1:0] acc_out,
  output logic [DW-1:0] cout,
  output logic          cout_signed
);
  localparam int NDEC = 3;
  localparam int PW   = 2*DW + 2;

  logic          den_q, cen_q;
  logic [DW-1:0] x_q, c_q;
  logic          xs_q, cs_q;
  logic [DW-1:0] dv_q [NDEC];
  logic          ds_q [NDEC];

  always_ff @(posedge clk) begin
    if (rst) begin
      den_q <= 1'b1;
      cen_q <= 1'b1;
      x_q   <= '0;
      xs_q  <= 1'b0;
    end else begin
      den_q <= din_en_n;
      cen_q <= cin_en_n;
      x_q   <= den_q ? '0 : din;
      xs_q  <= den_q ? 1'b0 : din_signed;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      c_q  <= '0;
      cs_q <= 1'b0;
    end else if (!cen_q) begin
      c_q  <= cin;
      cs_q <= cin_signed;
    end
  end

  for (genvar k = 0; k < NDEC; k++) begin : g_dec
    logic [DW-1:0] src_v;
    logic          src_s;
    if (k == 0) begin : g_first
      assign src_v = c_q;
      assign src_s = cs_q;
    end else begin : g_next
      assign src_v = dv_q[k-1];
      assign src_s = ds_q[k-1];
    end
    always_ff @(posedge clk) begin
      if (rst) begin
        dv_q[k] <= '0;
        ds_q[k] <= 1'b0;
      end else if (!cen_q && (decim_mode > 2'(k))) begin
        dv_q[k] <= src_v;
        ds_q[k] <= src_s;
      end
    end
  end

  always_comb begin
    if (decim_mode == 2'd0) begin
      cout        = c_q;
      cout_signed = cs_q;
    end else begin
      cout        = dv_q[decim_mode - 2'd1];
      cout_signed = ds_q[decim_mode - 2'd1];
    end
  end

  logic signed [DW:0]   x_ext, c_ext;
  logic signed [PW-1:0] prod;
  logic        [AW-1:0] prod_ext;

  assign x_ext    = {xs_q & x_q[DW-1], x_q};
  assign c_ext    = {cs_q & c_q[DW-1], c_q};
  assign prod     = PW'(x_ext) * PW'(c_ext);
  assign prod_ext = {{(AW-PW){prod[PW-1]}}, prod};

  always_ff @(posedge clk) begin
    if (rst)            acc_out <= '0;
    else if (acc_clear) acc_out <= prod_ext;
    else                acc_out <= acc_out + prod_ext;
  end
endmodule

// File: rtl/fir_tap_cell_chk.sv
module fir_tap_cell_chk #(
  parameter int DW = 8,
  parameter int AW = 26
) (
  input logic          clk,
  input logic          rst,
  input logic [DW-1:0] din,
  input logic          din_signed,
  input logic          din_en_n,
  input logic [DW-1:0] cin,
  input logic          cin_signed,
  input logic          cin_en_n,
  input logic [1:0]    decim_mode,
  input logic          acc_clear,
  input logic [AW-1:0] acc_out,
  input logic [DW-1:0] cout,
  input logic          cout_signed
);
  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (acc_out == '0 && cout == '0 && !cout_signed));

  assert_zero_data_R5: assert property (@(posedge clk) disable iff (rst)
    din_en_n |=> ##2 (acc_out == ($past(acc_clear) ? '0 : $past(acc_out))));

  assert_coef_hold_R7: assert property (@(posedge clk) disable iff (rst)
    cin_en_n |=> ##1 ($stable(decim_mode) |-> ($stable(cout) && $stable(cout_signed))));

  assert_direct_fwd_R8: assert property (@(posedge clk) disable iff (rst)
    !cin_en_n ##2 (decim_mode == 2'd0) |-> (cout == $past(cin) && cout_signed == $past(cin_signed)));
endmodule

bind fir_tap_cell fir_tap_cell_chk #(.DW(DW), .AW(AW)) u_chk (.*);

// File: tb/fir_tap_cell_tb.sv
module fir_tap_cell_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  din = '0, cin = '0;
  logic        din_signed = 1'b0, cin_signed = 1'b0;
  logic        din_en_n = 1'b1, cin_en_n = 1'b1;
  logic [1:0]  decim_mode = '0;
  logic        acc_clear = 1'b0;
  logic [25:0] acc_out;
  logic [7:0]  cout;
  logic        cout_signed;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  fir_tap_cell u_dut (.*);

  always #4 clk = ~clk;

  // reference state (value after the most recent rising edge)
  bit      m_den, m_cen;
  int      m_x, m_c;
  bit      m_xs, m_cs;
  int      m_dv [3];
  bit      m_ds [3];
  longint  m_acc;

  function automatic longint opv(int v, bit s);
    return (s && v >= 128) ? longint'(v) - 256 : longint'(v);
  endfunction

  task automatic check(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_den = 1; m_cen = 1; m_x = 0; m_xs = 0; m_c = 0; m_cs = 0; m_acc = 0;
    for (int i = 0; i < 3; i++) begin m_dv[i] = 0; m_ds[i] = 0; end
  endtask

  task automatic compare(string tag);
    int ev; bit es;
    if (decim_mode == 0) begin ev = m_c; es = m_cs; end
    else begin ev = m_dv[decim_mode-1]; es = m_ds[decim_mode-1]; end
    check({tag, " acc"}, acc_out, m_acc);
    check({tag, " cout"}, cout, ev);
    check({tag, " cout_signed R11"}, cout_signed, es);
  endtask

  // called after the inputs for the next edge are applied
  task automatic model_edge();
    longint p;
    if (rst) begin model_reset(); return; end
    p = opv(m_x, m_xs) * opv(m_c, m_cs);
    m_acc = (acc_clear ? p : m_acc + p) & ((64'd1 << 26) - 1);
    if (!m_cen) begin
      if (decim_mode >= 3) begin m_dv[2] = m_dv[1]; m_ds[2] = m_ds[1]; end
      if (decim_mode >= 2) begin m_dv[1] = m_dv[0]; m_ds[1] = m_ds[0]; end
      if (decim_mode >= 1) begin m_dv[0] = m_c;     m_ds[0] = m_cs;     end
      m_c = cin; m_cs = cin_signed;
    end
    if (!m_den) begin m_x = din; m_xs = din_signed; end
    else        begin m_x = 0;   m_xs = 0;          end
    m_den = din_en_n; m_cen = cin_en_n;
  endtask

  task automatic step(string tag, logic [7:0] d, bit ds, bit den, logic [7:0] c, bit cs,
                      bit cen, logic [1:0] md, bit clr);
    compare(tag);
    din = d; din_signed = ds; din_en_n = den; cin = c; cin_signed = cs;
    cin_en_n = cen; decim_mode = md; acc_clear = clr;
    model_edge();
    @(negedge clk);
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    compare("R1 reset");
    rst = 1'b0;
    model_edge();
    @(negedge clk);
    // R2: unsigned stream, mode 0
    for (int i = 0; i < 40; i++)
      step("R2 unsigned", 8'($urandom), 0, 0, 8'($urandom), 0, 0, 2'd0, i == 0);
    // R3/R11: every signedness combination
    for (int i = 0; i < 80; i++)
      step("R3 signed mix", 8'($urandom), i[1], 0, 8'($urandom), i[2], 0, 2'd0, i % 9 == 0);
    // R4/R5: toggle data enable
    for (int i = 0; i < 60; i++)
      step("R4 R5 data enable", 8'($urandom), i[0], ($urandom % 3) == 0, 8'($urandom), 1, 0, 2'd0, 0);
    for (int i = 0; i < 10; i++)
      step("R5 zero data", 8'hFF, 0, 1, 8'd77, 0, 0, 2'd0, 0);
    // R6/R7/R8: decimation modes with gated coefficient enable
    for (int m = 0; m < 4; m++)
      for (int i = 0; i < 40; i++)
        step("R6 R7 R8 decimation", 8'($urandom), 1, 0, 8'($urandom), i[0], ($urandom % 3) == 0, 2'(m), 0);
    for (int i = 0; i < 50; i++)
      step("R8 mode switching", 8'($urandom), 0, 0, 8'($urandom), i[1], i[2], 2'($urandom), 0);
    for (int i = 0; i < 12; i++)
      step("R7 hold", 8'd5, 0, 0, 8'($urandom), 1, 1, 2'd2, 0);
    // R9: clear pulses
    for (int i = 0; i < 40; i++)
      step("R9 clear", 8'($urandom), 1, 0, 8'($urandom), 0, 0, 2'd0, (i % 4) == 1);
    // R10: negative wrap via clear, then unsigned overflow
    for (int i = 0; i < 4; i++)
      step("R10 negative wrap", 8'h80, 1, 0, 8'h7F, 0, 0, 2'd0, 1);
    check("R10 negative wrap value", acc_out, 26'h3FFC080);
    for (int i = 0; i < 1100; i++)
      step("R10 overflow", 8'hFF, 0, 0, 8'hFF, 0, 0, 2'd0, 0);
    // R1: reset mid-run
    rst = 1'b1;
    model_edge();
    @(negedge clk);
    compare("R1 reset again");
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule